// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block tracks the coherence state of each line in a small write-back cache that sits on a snooping bus. Every line holds a two-bit state (Modified, Exclusive, Shared or Invalid) and one data word. Local processor reads, writes and evictions are served from the line when the state allows it. When the state does not allow it, the block raises a bus request carrying a read, a read-for-ownership or an invalidate command, and finishes the operation in the cycle after the grant.

Requests seen on the bus from other caches are answered in the same cycle. The block raises a shared response for a valid line. If it holds the line Modified, it supplies the word, raises a signal that cancels the memory reply, and pulses a write-back to memory. It then lowers its own state as the snooped command requires.

The command for a pending local write is chosen from the line state in the grant cycle. A write that loses a race to another writer therefore turns into a read-for-ownership and fetches the line again. The bus is assumed never to grant this cache in the same cycle as it presents a snoop.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. A first read of any line raises a bus read, and a snoop of any line raises neither the shared nor the intervention response.
- R2: A read of an Invalid line raises bus_req_o with command 01 (read). In the grant cycle the line is loaded from bus_data_i, as Exclusive if bus_shared_i is low and as Shared if it is high. cpu_rdata_o then returns the loaded word.
- R3: A read of a Shared, Exclusive or Modified line raises no bus request. cpu_done_o pulses one cycle after acceptance, with the stored word on cpu_rdata_o.
- R4: A write to a Shared line requests command 11 (invalidate) and a write to an Invalid line requests command 10 (read-for-ownership). After the grant the line is Modified and holds the write word, and cpu_rdata_o returns that word.
- R5: A write to an Exclusive or Modified line completes with no bus request, one cycle after acceptance. The line becomes Modified with the new word.
- R6: A snooped read (snp_cmd_i 01) of a valid line raises snp_shared_o in the same cycle. If the line is Modified, snp_intervene_o is raised, snp_data_o carries the word, and wb_valid_o pulses with that line's index and word. A Modified or Exclusive line then becomes Shared.
- R7: A snooped read-for-ownership (10) or invalidate (11) makes the line Invalid. A Modified line writes back in that cycle; it also intervenes for read-for-ownership and does not intervene for invalidate.
- R8: When a write is pending on a Shared line and a snoop invalidates that line before the grant, the request changes its command to read-for-ownership.
- R9: Eviction (cpu_op_i 10 or 11) makes the line Invalid and completes one cycle after acceptance, returning the old word. A Modified line pulses wb_valid_o in the acceptance cycle; any other state causes no write-back.
- R10: No local request is accepted in a cycle with snp_valid_i high.
- R11: bus_req_o holds, with a constant command and index, until bus_gnt_i. cpu_done_o follows one cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Local request, held until cpu_done_o |
| cpu_op_i | input | 2 | 00 read, 01 write, 1x evict |
| cpu_idx_i | input | IW | Line index of the local request |
| cpu_wdata_i | input | DW | Write word |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DW | Returned word, valid with cpu_done_o |
| bus_req_o | output | 1 | Bus request |
| bus_cmd_o | output | 2 | 01 read, 10 read-for-ownership, 11 invalidate |
| bus_idx_o | output | IW | Line index of the bus request |
| bus_gnt_i | input | 1 | Grant; the transaction occurs in this cycle |
| bus_shared_i | input | 1 | Another cache holds the line, sampled at grant |
| bus_data_i | input | DW | Fill word, sampled at grant |
| snp_valid_i | input | 1 | Snooped transaction present |
| snp_cmd_i | input | 2 | Snooped command, same encoding as bus_cmd_o |
| snp_idx_i | input | IW | Snooped line index |
| snp_shared_o | output | 1 | This cache holds the snooped line |
| snp_intervene_o | output | 1 | Cancel the memory reply; this cache supplies data |
| snp_data_o | output | DW | Supplied word during intervention |
| wb_valid_o | output | 1 | Write-back to memory this cycle |
| wb_idx_o | output | IW | Write-back line index |
| wb_data_o | output | DW | Write-back word |

## Verification
A wrong line state is not visible at once. It shows when that line is next touched. A line wrongly left valid answers a snoop with a shared or intervention response that should be absent. A line that is wrongly Shared instead of Exclusive makes the next write issue an invalidate when no bus request should appear. A lost Modified state drops a write-back on eviction or snoop. Every operation is therefore checked against a reference model, so that a corrupted state is reported on the first later access to the same line.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_st_e;

  typedef enum logic [1:0] {
    BC_NONE = 2'b00,
    BC_RD   = 2'b01,
    BC_RDX  = 2'b10,
    BC_INV  = 2'b11
  } bus_cmd_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'b00,
    F_WAIT = 2'b01,
    F_RESP = 2'b10
  } fsm_e;
endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int LINES = 8,
  parameter int DW    = 32,
  parameter int IW    = $clog2(LINES)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [IW-1:0]  cpu_idx_i,
  input  logic [IW-1:0]  snp_idx_i,
  input  logic           snp_upd_i,
  input  mesi_st_e       snp_st_i,
  input  logic           loc_upd_i,
  input  logic [IW-1:0]  loc_idx_i,
  input  mesi_st_e       loc_st_i,
  input  logic           loc_wr_i,
  input  logic [DW-1:0]  loc_data_i,
  output mesi_st_e       cpu_st_o,
  output logic [DW-1:0]  cpu_data_o,
  output mesi_st_e       snp_st_o,
  output logic [DW-1:0]  snp_data_o
);
  mesi_st_e    st_q   [LINES];
  logic [DW-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic snp_hit, loc_hit;
    assign snp_hit = snp_upd_i && (snp_idx_i == IW'(g));
    assign loc_hit = loc_upd_i && (loc_idx_i == IW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[g]   <= ST_I;
        data_q[g] <= '0;
      end else begin
        // snoop wins: bus order is fixed before local
        if (snp_hit)      st_q[g] <= snp_st_i;
        else if (loc_hit) st_q[g] <= loc_st_i;
        if (loc_hit && loc_wr_i) data_q[g] <= loc_data_i;
      end
    end
  end

  assign cpu_st_o   = st_q[cpu_idx_i];
  assign cpu_data_o = data_q[cpu_idx_i];
  assign snp_st_o   = st_q[snp_idx_i];
  assign snp_data_o = data_q[snp_idx_i];

  // R10: local and snoop updates never collide on one line
  a_r10_no_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(snp_upd_i && loc_upd_i && snp_idx_i == loc_idx_i));
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           snp_valid_i,
  input  bus_cmd_e       snp_cmd_i,
  input  mesi_st_e       st_i,
  input  logic [DW-1:0]  data_i,
  output logic           shared_o,
  output logic           intervene_o,
  output logic [DW-1:0]  data_o,
  output logic           wb_o,
  output logic           upd_o,
  output mesi_st_e       st_o
);
  logic hit, dirty;
  assign hit   = snp_valid_i && (st_i != ST_I);
  assign dirty = snp_valid_i && (st_i == ST_M);

  always_comb begin
    shared_o    = 1'b0;
    intervene_o = 1'b0;
    wb_o        = 1'b0;
    upd_o       = 1'b0;
    st_o        = ST_I;
    unique case (snp_cmd_i)
      BC_RD: begin
        shared_o    = hit;
        intervene_o = dirty;
        wb_o        = dirty;
        upd_o       = hit;
        st_o        = ST_S;
      end
      BC_RDX: begin
        intervene_o = dirty;
        wb_o        = dirty;
        upd_o       = hit;
      end
      BC_INV: begin
        wb_o  = dirty;
        upd_o = hit;
      end
      default: ;
    endcase
  end

  assign data_o = intervene_o ? data_i : '0;

  // R6: intervention always carries a memory update
  a_r6_intervene_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intervene_o |-> wb_o && snp_cmd_i != BC_INV);
  // R6: shared response only from a held line
  a_r6_shared_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shared_o |-> upd_o && !wb_o || intervene_o);
endmodule

// File: rtl/mesi_local_fsm.sv
module mesi_local_fsm
  import mesi_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cpu_req_i,
  input  logic [1:0]     cpu_op_i,
  input  logic [IW-1:0]  cpu_idx_i,
  input  logic [DW-1:0]  cpu_wdata_i,
  output logic           cpu_done_o,
  output logic [DW-1:0]  cpu_rdata_o,
  output logic           bus_req_o,
  output bus_cmd_e       bus_cmd_o,
  output logic [IW-1:0]  bus_idx_o,
  input  logic           bus_gnt_i,
  input  logic           bus_shared_i,
  input  logic [DW-1:0]  bus_data_i,
  input  logic           snp_valid_i,
  output logic [IW-1:0]  look_idx_o,
  input  mesi_st_e       look_st_i,
  input  logic [DW-1:0]  look_data_i,
  output logic           loc_upd_o,
  output mesi_st_e       loc_st_o,
  output logic           loc_wr_o,
  output logic [DW-1:0]  loc_data_o,
  output logic           ev_wb_o
);
  fsm_e          fsm_q, fsm_d;
  logic [IW-1:0] idx_q;
  logic          wr_q;
  logic [DW-1:0] wdata_q, rdata_q, rdata_d;
  logic          accept, is_ev, is_wr, owned;

  assign accept = (fsm_q == F_IDLE) && cpu_req_i && !snp_valid_i;
  assign is_ev  = cpu_op_i[1];
  assign is_wr  = !cpu_op_i[1] && cpu_op_i[0];
  assign owned  = (look_st_i == ST_E) || (look_st_i == ST_M);
  assign look_idx_o = (fsm_q == F_IDLE) ? cpu_idx_i : idx_q;

  always_comb begin
    fsm_d      = fsm_q;
    rdata_d    = rdata_q;
    loc_upd_o  = 1'b0;
    loc_st_o   = ST_I;
    loc_wr_o   = 1'b0;
    loc_data_o = '0;
    ev_wb_o    = 1'b0;
    bus_req_o  = 1'b0;
    bus_cmd_o  = BC_NONE;
    unique case (fsm_q)
      F_IDLE: if (accept) begin
        rdata_d = look_data_i;
        if (is_ev) begin
          loc_upd_o = 1'b1;
          ev_wb_o   = (look_st_i == ST_M);
          fsm_d     = F_RESP;
        end else if (is_wr) begin
          if (owned) begin
            loc_upd_o  = 1'b1;
            loc_st_o   = ST_M;
            loc_wr_o   = 1'b1;
            loc_data_o = cpu_wdata_i;
            rdata_d    = cpu_wdata_i;
            fsm_d      = F_RESP;
          end else begin
            fsm_d = F_WAIT;
          end
        end else begin
          fsm_d = (look_st_i != ST_I) ? F_RESP : F_WAIT;
        end
      end
      F_WAIT: begin
        bus_req_o = 1'b1;
        // chosen from the present state so a lost race refetches
        if (!wr_q)                  bus_cmd_o = BC_RD;
        else if (look_st_i == ST_S) bus_cmd_o = BC_INV;
        else                        bus_cmd_o = BC_RDX;
        if (bus_gnt_i) begin
          loc_upd_o  = 1'b1;
          loc_wr_o   = 1'b1;
          loc_st_o   = wr_q ? ST_M : (bus_shared_i ? ST_S : ST_E);
          loc_data_o = wr_q ? wdata_q : bus_data_i;
          rdata_d    = wr_q ? wdata_q : bus_data_i;
          fsm_d      = F_RESP;
        end
      end
      F_RESP: fsm_d = F_IDLE;
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q   <= F_IDLE;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      fsm_q   <= fsm_d;
      rdata_q <= rdata_d;
      if (accept) begin
        idx_q   <= cpu_idx_i;
        wr_q    <= is_wr;
        wdata_q <= cpu_wdata_i;
      end
    end
  end

  assign cpu_done_o  = (fsm_q == F_RESP);
  assign cpu_rdata_o = rdata_q;
  assign bus_idx_o   = idx_q;

  // R11: request held steady until granted
  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_idx_o));
  // R11: completion one cycle after the grant
  a_r11_done_after_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i |=> cpu_done_o && !bus_req_o);
  // R5: owned write is silent
  a_r5_silent_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && is_wr && owned |=> cpu_done_o && !bus_req_o);
  // R10: nothing starts during a snoop
  a_r10_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == F_IDLE) && snp_valid_i |=> !cpu_done_o && !bus_req_o);
  // R4: granted write leaves the line Modified
  a_r4_write_owns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i && wr_q |=> look_st_i == ST_M);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> !cpu_done_o);
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int LINES = 8,
  parameter int DW    = 32,
  parameter int IW    = $clog2(LINES)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cpu_req_i,
  input  logic [1:0]     cpu_op_i,
  input  logic [IW-1:0]  cpu_idx_i,
  input  logic [DW-1:0]  cpu_wdata_i,
  output logic           cpu_done_o,
  output logic [DW-1:0]  cpu_rdata_o,
  output logic           bus_req_o,
  output logic [1:0]     bus_cmd_o,
  output logic [IW-1:0]  bus_idx_o,
  input  logic           bus_gnt_i,
  input  logic           bus_shared_i,
  input  logic [DW-1:0]  bus_data_i,
  input  logic           snp_valid_i,
  input  logic [1:0]     snp_cmd_i,
  input  logic [IW-1:0]  snp_idx_i,
  output logic           snp_shared_o,
  output logic           snp_intervene_o,
  output logic [DW-1:0]  snp_data_o,
  output logic           wb_valid_o,
  output logic [IW-1:0]  wb_idx_o,
  output logic [DW-1:0]  wb_data_o
);
  logic [IW-1:0] look_idx;
  mesi_st_e      look_st, snp_st, loc_st, snp_nst;
  logic [DW-1:0] look_data, snp_line_data, loc_data;
  logic          loc_upd, loc_wr, ev_wb, snp_wb, snp_upd;
  bus_cmd_e      bus_cmd;

  mesi_state_array #(.LINES(LINES), .DW(DW), .IW(IW)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_idx_i  (look_idx),
    .snp_idx_i  (snp_idx_i),
    .snp_upd_i  (snp_upd),
    .snp_st_i   (snp_nst),
    .loc_upd_i  (loc_upd),
    .loc_idx_i  (look_idx),
    .loc_st_i   (loc_st),
    .loc_wr_i   (loc_wr),
    .loc_data_i (loc_data),
    .cpu_st_o   (look_st),
    .cpu_data_o (look_data),
    .snp_st_o   (snp_st),
    .snp_data_o (snp_line_data)
  );

  mesi_snoop_resp #(.DW(DW)) u_snoop (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .snp_valid_i (snp_valid_i),
    .snp_cmd_i   (bus_cmd_e'(snp_cmd_i)),
    .st_i        (snp_st),
    .data_i      (snp_line_data),
    .shared_o    (snp_shared_o),
    .intervene_o (snp_intervene_o),
    .data_o      (snp_data_o),
    .wb_o        (snp_wb),
    .upd_o       (snp_upd),
    .st_o        (snp_nst)
  );

  mesi_local_fsm #(.DW(DW), .IW(IW)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_req_i    (cpu_req_i),
    .cpu_op_i     (cpu_op_i),
    .cpu_idx_i    (cpu_idx_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_done_o   (cpu_done_o),
    .cpu_rdata_o  (cpu_rdata_o),
    .bus_req_o    (bus_req_o),
    .bus_cmd_o    (bus_cmd),
    .bus_idx_o    (bus_idx_o),
    .bus_gnt_i    (bus_gnt_i),
    .bus_shared_i (bus_shared_i),
    .bus_data_i   (bus_data_i),
    .snp_valid_i  (snp_valid_i),
    .look_idx_o   (look_idx),
    .look_st_i    (look_st),
    .look_data_i  (look_data),
    .loc_upd_o    (loc_upd),
    .loc_st_o     (loc_st),
    .loc_wr_o     (loc_wr),
    .loc_data_o   (loc_data),
    .ev_wb_o      (ev_wb)
  );

  assign bus_cmd_o  = bus_cmd;
  // evictions only start without a snoop, so the sources never overlap
  assign wb_valid_o = snp_wb | ev_wb;
  assign wb_idx_o   = snp_wb ? snp_idx_i : look_idx;
  assign wb_data_o  = snp_wb ? snp_line_data : look_data;

  // R9: write-back sources are exclusive
  a_r9_wb_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(snp_wb && ev_wb));
  // R2: bus request carries a real command
  a_r2_req_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> bus_cmd_o != 2'b00);
endmodule

// File: tb/mesi_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb_top;
  localparam int LINES = 8;
  localparam int DW = 32;
  localparam int IW = 3;
  localparam logic [1:0] S_I = 2'b00, S_S = 2'b01, S_E = 2'b10, S_M = 2'b11;
  localparam logic [1:0] C_RD = 2'b01, C_RDX = 2'b10, C_INV = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, bus_gnt = 0, bus_shared = 0, snp_valid = 0;
  logic [1:0] cpu_op = 0, snp_cmd = 0;
  logic [IW-1:0] cpu_idx = 0, snp_idx = 0;
  logic [DW-1:0] cpu_wdata = 0, bus_data = 0;
  logic cpu_done, bus_req, snp_shared, snp_intervene, wb_valid;
  logic [1:0] bus_cmd;
  logic [IW-1:0] bus_idx, wb_idx;
  logic [DW-1:0] cpu_rdata, snp_data, wb_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [1:0] m_st [LINES];
  logic [DW-1:0] m_data [LINES];

  always #4 clk = ~clk;

  mesi_line_ctrl #(.LINES(LINES), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_op_i(cpu_op), .cpu_idx_i(cpu_idx), .cpu_wdata_i(cpu_wdata),
    .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_idx_o(bus_idx),
    .bus_gnt_i(bus_gnt), .bus_shared_i(bus_shared), .bus_data_i(bus_data),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_idx_i(snp_idx),
    .snp_shared_o(snp_shared), .snp_intervene_o(snp_intervene), .snp_data_o(snp_data),
    .wb_valid_o(wb_valid), .wb_idx_o(wb_idx), .wb_data_o(wb_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_cmd(input logic wr, input logic [1:0] st);
    if (!wr) return C_RD;
    return (st == S_S) ? C_INV : C_RDX;
  endfunction

  task automatic cpu_do(input logic [1:0] op, input logic [IW-1:0] idx, input logic [DW-1:0] wd,
                        input logic shd, input logic [DW-1:0] fill, input int dly);
    logic [1:0] st;
    logic ev, wr, needbus;
    logic [DW-1:0] exp_rd;
    @(negedge clk);
    cpu_req = 1; cpu_op = op; cpu_idx = idx; cpu_wdata = wd;
    #1;
    st = m_st[idx];
    ev = op[1];
    wr = !op[1] && op[0];
    chk("R9 evict wb_valid", wb_valid, ev && st == S_M);
    if (ev && st == S_M) chk("R9 evict wb_data", wb_data, m_data[idx]);
    needbus = !ev && ((!wr && st == S_I) || (wr && (st == S_I || st == S_S)));
    @(negedge clk);
    if (needbus) begin
      chk("R11 bus_req", bus_req, 1);
      chk(wr ? "R4 bus_cmd" : "R2 bus_cmd", bus_cmd, exp_cmd(wr, st));
      chk("R11 bus_idx", bus_idx, idx);
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        chk("R11 req held", {bus_req, bus_cmd, cpu_done}, {1'b1, exp_cmd(wr, st), 1'b0});
      end
      bus_gnt = 1; bus_shared = shd; bus_data = fill;
      @(negedge clk);
      bus_gnt = 0;
      if (wr) begin m_st[idx] = S_M; m_data[idx] = wd; exp_rd = wd; end
      else begin m_st[idx] = shd ? S_S : S_E; m_data[idx] = fill; exp_rd = fill; end
    end else begin
      chk("R3 no bus req", bus_req, 0);
      exp_rd = wr ? wd : m_data[idx];
      if (ev) m_st[idx] = S_I;
      else if (wr) begin m_st[idx] = S_M; m_data[idx] = wd; end
    end
    chk("R3 done", cpu_done, 1);
    chk(wr ? "R5 rdata" : "R2 rdata", cpu_rdata, exp_rd);
    cpu_req = 0;
    @(negedge clk);
    chk("R11 done pulse", cpu_done, 0);
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [IW-1:0] idx);
    logic [1:0] st;
    logic ivn;
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_idx = idx;
    #1;
    st = m_st[idx];
    ivn = (st == S_M) && (cmd == C_RD || cmd == C_RDX);
    chk("R6 snp_shared", snp_shared, cmd == C_RD && st != S_I);
    chk(cmd == C_RD ? "R6 intervene" : "R7 intervene", snp_intervene, ivn);
    chk(cmd == C_RD ? "R6 wb_valid" : "R7 wb_valid", wb_valid, st == S_M);
    if (ivn) chk("R6 snp_data", snp_data, m_data[idx]);
    if (st == S_M) chk("R7 wb_idx_data", {wb_idx, wb_data}, {idx, m_data[idx]});
    if (cmd == C_RD) begin if (st != S_I) m_st[idx] = S_S; end
    else m_st[idx] = S_I;
    @(negedge clk);
    snp_valid = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < LINES; i++) begin m_st[i] = S_I; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {cpu_done, bus_req, wb_valid}, 0);
    for (int i = 0; i < LINES; i++) snoop(C_RD, IW'(i));
    // directed
    cpu_do(2'b00, 0, 0, 0, 32'hA0A0_0001, 1);   // R1 R2 miss -> E
    cpu_do(2'b01, 0, 32'h1111_0000, 0, 0, 0);   // R5 silent write E->M
    cpu_do(2'b00, 0, 0, 0, 0, 0);               // R3 read hit
    snoop(C_RD, 0);                             // R6 M intervenes -> S
    cpu_do(2'b01, 0, 32'h2222_0000, 0, 0, 2);   // R4 INV from S
    cpu_do(2'b10, 0, 0, 0, 0, 0);               // R9 evict M
    cpu_do(2'b00, 0, 0, 0, 32'h3, 0);           // R1 R2 line now I
    cpu_do(2'b00, 1, 0, 1, 32'hB0B0_0002, 0);   // R2 shared fill -> S
    cpu_do(2'b11, 1, 0, 0, 0, 0);               // R9 silent evict
    cpu_do(2'b01, 2, 32'hC0C0_0003, 0, 0, 3);   // R4 RDX from I
    snoop(C_INV, 2);                            // R7 M invalidate: wb, no intervene
    cpu_do(2'b01, 2, 32'hC0C0_0004, 0, 0, 0);   // R7 refetch via RDX
    snoop(C_RDX, 2);                            // R7 M RDX: intervene + wb
    cpu_do(2'b00, 4, 0, 0, 32'hD4, 0);          // E
    snoop(C_RDX, 4);                            // R7 E -> I silently
    cpu_do(2'b00, 4, 0, 0, 32'hD5, 0);          // R7 verify I via bus read
    // R8 race
    cpu_do(2'b00, 3, 0, 1, 32'hE3, 0);
    @(negedge clk);
    cpu_req = 1; cpu_op = 2'b01; cpu_idx = 3; cpu_wdata = 32'hF00D_0003;
    @(negedge clk);
    chk("R8 initial cmd", {bus_req, bus_cmd}, {1'b1, C_INV});
    snp_valid = 1; snp_cmd = C_RDX; snp_idx = 3;
    #1;
    chk("R8 snoop on S", {snp_shared, snp_intervene, wb_valid}, 0);
    @(negedge clk);
    snp_valid = 0;
    m_st[3] = S_I;
    #1;
    chk("R8 cmd after race", {bus_req, bus_cmd, bus_idx}, {1'b1, C_RDX, 3'd3});
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    chk("R8 done", {cpu_done, cpu_rdata}, {1'b1, 32'hF00D_0003});
    m_st[3] = S_M; m_data[3] = 32'hF00D_0003;
    cpu_req = 0;
    @(negedge clk);
    // R10 stall under snoop
    cpu_req = 1; cpu_op = 2'b00; cpu_idx = 3;
    snp_valid = 1; snp_cmd = C_RD; snp_idx = 6;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 stalled", {cpu_done, bus_req}, 0);
    end
    snp_valid = 0;
    @(negedge clk);
    chk("R10 accepted after snoop", {cpu_done, cpu_rdata}, {1'b1, 32'hF00D_0003});
    cpu_req = 0;
    @(negedge clk);
    // random mix
    for (int n = 0; n < 500; n++) begin
      int r;
      r = $urandom % 10;
      if (r < 6)
        cpu_do(2'($urandom), IW'($urandom), $urandom, 1'($urandom), $urandom, $urandom % 4);
      else
        snoop(2'($urandom % 3 + 1), IW'($urandom));
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule